// File: doc/BRIEF.md
# Stochastic Bitstream Operator Bank

This block groups the basic single-bit operators of stochastic computing behind one clock, one synchronous reset and one enable. Every signal is a serial stream of bits whose value is carried by the density of ones. In unipolar coding a stream holding k ones in L bits has the value k/L, in the range 0 to 1. In bipolar coding the same stream has the value 2·(k/L − 0.5), in the range −1 to 1. The bank holds these operators:

- a multiplier over `N_IN` operands in unipolar form;
- the same multiplier in bipolar form;
- a scaled adder over `N_IN` operands;
- a squarer;
- a complement unit.

The multipliers, the complement unit and the data path of the adder have no register in them. The adder picks one operand per cycle with a deterministic round-robin pointer, so its output density is the mean of the operand densities. The squarer ANDs the present bit with the bit from the previous enabled cycle. This gives the product of two samples of one stream that are, in effect, uncorrelated. The operand count is a parameter, so products and averages of three or more streams come out of a single gate level. Converting to and from binary and nonlinear state-machine operators belong to the blocks around this one.

Top module: `sc_op_bank`

## Requirements
- R1: While `en` is high, `prod_u` is 1 exactly when every bit of `mul_in` is 1.
- R2: While `en` is high, `prod_b` is 1 exactly when the number of 0 bits in `mul_in` is even (zero counts as even). For bipolar streams this is their product.
- R3: While `en` is high, `avg_out` equals `add_in[p]`, where p is an internal pointer. Reset sets p to 0. Each clock edge with `en` high moves p to (p+1) mod `N_IN`.
- R4: A clock edge with `en` low leaves the adder pointer unchanged. The next enabled cycle selects the same operand that the next step would have selected without the pause.
- R5: While `en` is high, `sq_out` = `sq_in` AND d. Here d is the value of `sq_in` at the most recent enabled clock edge. Reset sets d to 0, so the first enabled cycle after reset gives 0.
- R6: While `en` is high, `cmp_out` is the inverse of `cmp_in`.
- R7: While `en` is low, all five outputs are 0.
- R8: Over 512 enabled cycles of independent random streams, the measured one-densities match the expected results to within 0.06 for unipolar outputs and 0.12 for the bipolar output. The expected results are the product of the operand densities, their mean, the square, and the complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operator enable |
| mul_in | input | N_IN | Multiplier operand streams |
| add_in | input | N_IN | Adder operand streams |
| sq_in | input | 1 | Squarer input stream |
| cmp_in | input | 1 | Complement input stream |
| prod_u | output | 1 | Unipolar product stream |
| prod_b | output | 1 | Bipolar product stream |
| avg_out | output | 1 | Scaled-sum (mean) stream |
| sq_out | output | 1 | Square stream |
| cmp_out | output | 1 | Complement stream |

## Verification
The bench targets three edge cases:

- **Pointer wrap at N_IN−1.** An adder whose pointer failed to wrap there would repeat or skip an operand, and its mean would drift.
- **Pauses in `en`.** A pointer that kept moving through a pause would pick the wrong operand after every gap in `en`.
- **Squarer delay after reset.** A squarer whose delay register did not clear would emit a stale 1 on the first enabled cycle. One that also loaded while disabled would square against a sample that was never enabled.

The bipolar multiplier runs with an odd operand count. A plain reduction XNOR inverts the result there, so its density check would land near the negative of the true product.

// File: rtl/sc_arith_pkg.sv
package sc_arith_pkg;

  typedef enum logic {
    ENC_UNIPOLAR = 1'b0,
    ENC_BIPOLAR  = 1'b1
  } sc_enc_e;

  // Round-robin successor of a pointer over n slots.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Unipolar stream product: all operands high.
  function automatic logic uni_product(input logic [31:0] bits, input int unsigned n);
    logic r;
    r = 1'b1;
    for (int unsigned i = 0; i < n; i++) r = r & bits[i];
    return r;
  endfunction

  // Bipolar stream product: high when the count of low operands is even.
  function automatic logic bip_product(input logic [31:0] bits, input int unsigned n);
    logic par;
    par = 1'b0;
    for (int unsigned i = 0; i < n; i++) par = par ^ ~bits[i];
    return ~par;
  endfunction

endpackage

// File: rtl/sc_mult.sv
module sc_mult
  import sc_arith_pkg::*;
#(
  parameter int unsigned N_IN = 3,
  parameter sc_enc_e     ENC  = ENC_UNIPOLAR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [N_IN-1:0] ops,
  output logic            prod
);
  localparam int unsigned PADW = 32;

  logic [PADW-1:0] ops_pad;
  logic            raw_prod;

  assign ops_pad = PADW'(ops);

  generate
    if (ENC == ENC_BIPOLAR) begin : g_bip
      assign raw_prod = bip_product(ops_pad, N_IN);
      // R2: output high iff the count of low operands is even
      a_r2_even_zeros: assert property (@(posedge clk) disable iff (rst)
        en |-> (prod == (((N_IN - $countones(ops)) % 2) == 0)));
    end else begin : g_uni
      assign raw_prod = uni_product(ops_pad, N_IN);
      // R1: a high product needs every operand high
      a_r1_all_high: assert property (@(posedge clk) disable iff (rst)
        (en && prod) |-> ($countones(ops) == N_IN));
    end
  endgenerate

  assign prod = en & raw_prod;

endmodule

// File: rtl/sc_avg_mux.sv
module sc_avg_mux
  import sc_arith_pkg::*;
#(
  parameter int unsigned N_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [N_IN-1:0] ops,
  output logic            avg
);
  localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_nxt;
  logic             picked;

  assign sel_nxt = SEL_W'(rr_next(int'(sel_q), N_IN));

  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (en) sel_q <= sel_nxt;
  end

  assign picked = ops[sel_q];
  assign avg    = en & picked;

  // R3: pointer never leaves the operand range
  a_r3_sel_range: assert property (@(posedge clk) disable iff (rst)
    32'(sel_q) < N_IN);
  // R3: enabled edge moves the pointer to its modulo successor
  a_r3_sel_step: assert property (@(posedge clk) disable iff (rst)
    en |=> (32'(sel_q) == ((32'($past(sel_q)) + 1) % N_IN)));
  // R4: disabled edge holds the pointer
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sel_q));

endmodule

// File: rtl/sc_square.sv
module sc_square (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic x,
  output logic sq
);
  logic dly_q;

  always_ff @(posedge clk) begin
    if (rst)     dly_q <= 1'b0;
    else if (en) dly_q <= x;
  end

  assign sq = en & x & dly_q;

  // R5: a high square needs a high input at the previous enabled edge
  a_r5_sq_prev: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && sq) |-> $past(x));
  // R5: a disabled edge leaves the delay register alone
  a_r5_dly_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dly_q));

endmodule

// File: rtl/sc_cmpl.sv
module sc_cmpl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic x,
  output logic y
);
  assign y = en & ~x;

  // R6: output opposes the input while enabled
  a_r6_invert: assert property (@(posedge clk) disable iff (rst)
    en |-> (y != x));

endmodule

// File: rtl/sc_op_bank.sv
module sc_op_bank
  import sc_arith_pkg::*;
#(
  parameter int unsigned N_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [N_IN-1:0] mul_in,
  input  logic [N_IN-1:0] add_in,
  input  logic            sq_in,
  input  logic            cmp_in,
  output logic            prod_u,
  output logic            prod_b,
  output logic            avg_out,
  output logic            sq_out,
  output logic            cmp_out
);

  sc_mult #(.N_IN(N_IN), .ENC(ENC_UNIPOLAR)) u_mul_u (
    .clk(clk), .rst(rst), .en(en), .ops(mul_in), .prod(prod_u)
  );

  sc_mult #(.N_IN(N_IN), .ENC(ENC_BIPOLAR)) u_mul_b (
    .clk(clk), .rst(rst), .en(en), .ops(mul_in), .prod(prod_b)
  );

  sc_avg_mux #(.N_IN(N_IN)) u_avg (
    .clk(clk), .rst(rst), .en(en), .ops(add_in), .avg(avg_out)
  );

  sc_square u_sq (
    .clk(clk), .rst(rst), .en(en), .x(sq_in), .sq(sq_out)
  );

  sc_cmpl u_cmp (
    .clk(clk), .rst(rst), .en(en), .x(cmp_in), .y(cmp_out)
  );

  // R7: disabled bank is silent on every output
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> !(prod_u || prod_b || avg_out || sq_out || cmp_out));

endmodule

// File: tb/sc_op_bank_tb.sv
module sc_op_bank_tb;
  localparam int N     = 3;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [N-1:0] mul_in = '0;
  logic [N-1:0] add_in = '0;
  logic         sq_in  = 1'b0;
  logic         cmp_in = 1'b0;
  logic         prod_u, prod_b, avg_out, sq_out, cmp_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference state
  int   m_ptr  = 0;
  logic m_prev = 1'b0;

  // density accumulators
  int acc_u, acc_b, acc_a, acc_s, acc_c, acc_n;
  bit acc_on = 0;

  always #(CLK_P/2) clk = ~clk;

  sc_op_bank #(.N_IN(N)) u_dut (
    .clk(clk), .rst(rst), .en(en), .mul_in(mul_in), .add_in(add_in),
    .sq_in(sq_in), .cmp_in(cmp_in), .prod_u(prod_u), .prod_b(prod_b),
    .avg_out(avg_out), .sq_out(sq_out), .cmp_out(cmp_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_real(input string tag, input real act, input real exp, input real tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  function automatic logic bern(input int permille);
    return ($urandom_range(999) < permille) ? 1'b1 : 1'b0;
  endfunction

  // one clock: drive at negedge, compare mid-low, update model after posedge
  task automatic cyc(input logic r, input logic e, input logic [N-1:0] m,
                     input logic [N-1:0] a, input logic s, input logic c);
    int zeros;
    logic eu, eb, ea, es, ec;
    @(negedge clk);
    rst = r; en = e; mul_in = m; add_in = a; sq_in = s; cmp_in = c;
    #(CLK_P/4);
    if (!r) begin
      zeros = 0;
      for (int i = 0; i < N; i++) if (!m[i]) zeros++;
      eu = e & (zeros == 0);
      eb = e & ((zeros % 2) == 0);
      ea = e & a[m_ptr];
      es = e & s & m_prev;
      ec = e & ~c;
      if (e) begin
        chk("R1 prod_u", prod_u, eu);
        chk("R2 prod_b", prod_b, eb);
        chk("R3 avg_out", avg_out, ea);
        chk("R5 sq_out", sq_out, es);
        chk("R6 cmp_out", cmp_out, ec);
      end else begin
        chk("R7 quiet", prod_u | prod_b | avg_out | sq_out | cmp_out, 1'b0);
      end
      if (acc_on && e) begin
        acc_u += prod_u; acc_b += prod_b; acc_a += avg_out;
        acc_s += sq_out; acc_c += cmp_out; acc_n++;
      end
    end
    @(posedge clk);
    if (r) begin
      m_ptr = 0; m_prev = 1'b0;
    end else if (e) begin
      m_ptr  = (m_ptr + 1) % N;
      m_prev = s;
    end
  endtask

  function automatic logic [N-1:0] rnd_vec();
    return N'($urandom);
  endfunction

  initial begin
    // reset, outputs checked quiet right after release
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, '1, '1, 1'b1, 1'b0); // R7: disabled with live inputs
    // R5: first enabled cycle after reset, input high, delay cleared -> 0
    cyc(1'b0, 1'b1, '1, 3'b001, 1'b1, 1'b1);
    // R3: pointer walk, one-hot add_in exposes which operand is chosen
    for (int k = 0; k < 2 * N + 1; k++)
      cyc(1'b0, 1'b1, rnd_vec(), N'(1 << ((k + 1) % N)), $urandom_range(1), $urandom_range(1));
    // R1/R2 corner patterns: all ones, all zeros, single zero
    cyc(1'b0, 1'b1, '1, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, '0, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 3'b110, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 3'b100, '0, 1'b0, 1'b0);
    // R4/R5: random enable pauses
    for (int k = 0; k < 200; k++)
      cyc(1'b0, $urandom_range(1), rnd_vec(), rnd_vec(), $urandom_range(1), $urandom_range(1));
    // R5: reset mid-stream, delay must clear
    cyc(1'b0, 1'b1, '0, '0, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, '0, '0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0, 3'b001, 1'b1, 1'b0);
    // R8: density run over 512 enabled cycles
    acc_u = 0; acc_b = 0; acc_a = 0; acc_s = 0; acc_c = 0; acc_n = 0;
    acc_on = 1;
    for (int k = 0; k < 512; k++) begin
      logic [N-1:0] mv, av;
      mv = {bern(500), bern(500), bern(750)};
      av = {bern(1000), bern(500), bern(250)};
      cyc(1'b0, 1'b1, mv, av, bern(500), bern(250));
    end
    acc_on = 0;
    chk_real("R8 unipolar product", real'(acc_u) / acc_n, 0.1875, 0.06);
    chk_real("R8 bipolar product", 2.0 * real'(acc_b) / acc_n - 1.0, 0.0, 0.12);
    chk_real("R8 mean", real'(acc_a) / acc_n, 0.5833, 0.06);
    chk_real("R8 square", real'(acc_s) / acc_n, 0.25, 0.06);
    chk_real("R8 complement", real'(acc_c) / acc_n, 0.75, 0.06);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule